// File: doc/BRIEF.md
# ATM Receive Cell Format Selector

This block sits between a receive framer and a byte-wide FIFO-side port. The framer has already found the slot boundaries. It hands over a stream of 57-octet slots, one octet per valid cycle, and marks the first octet of each slot. The first four octets of a slot are framing overhead. The remaining 53 octets are the ATM cell: a 5-octet header whose fifth octet is the HEC, followed by a 48-octet payload. A 2-bit mode picks how much of each slot is forwarded: the whole slot, the full cell, the cell with the HEC removed, or the payload alone. A separate select forces full-cell output whatever the mode.

Idle cells are never forwarded. An upstream checker reports a cell with a bad HEC or a failed header filter by raising a per-cell discard flag, and that cell is dropped as well. The drop decision can only be made once the HEC octet has arrived. Until then, incoming octets wait in a small ring buffer.

Every forwarded octet carries an odd-parity bit. The first octet sent for each cell carries a start-of-cell flag. The output is a plain valid/data stream with no back-pressure.

Top module: `atm_rx_cell_fmt`

## Requirements
- R1: While reset is asserted, and on the first clock edges after its release with no input, `out_valid` is 0.
- R2: With mode 2'b00, all 57 octets of a forwarded slot appear on `out_data` in arrival order.
- R3: With mode 2'b01, slot octets 4 through 56 (counting the slot-start octet as 0) appear in order.
- R4: With mode 2'b10, slot octets 4 through 7 and 9 through 56 appear in order, so the HEC octet at position 8 is omitted.
- R5: With mode 2'b11, only slot octets 9 through 56 appear in order.
- R6: While `utopia_sel` is 1, output follows the R3 pattern whatever the value of `mode`.
- R7: A slot whose octets 4, 5, 6 and 7 are 0x00, 0x00, 0x00 and 0x01 produces no output. Any other value in those four positions is forwarded normally.
- R8: A slot for which `in_discard` is 1 on its position-8 octet produces no output. `in_discard` is ignored on every other octet.
- R9: On every cycle where `out_valid` is 1, the nine bits `out_data` and `out_par` together contain an odd number of ones.
- R10: `out_sop` is 1 on the first output octet of each forwarded slot and 0 on every other output octet.
- R11: `mode` and `utopia_sel` are sampled with the position-8 octet of each slot. Later changes within the same slot do not alter that slot's output.
- R12: The following produce no output and do not disturb later slots: a slot cut short by a new `in_sos` before its position-8 octet, octets that arrive with `in_sos` low before any slot has started, and octets that follow position 56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input octet present |
| in_data | input | 8 | Input octet |
| in_sos | input | 1 | Input octet is position 0 of a slot |
| in_discard | input | 1 | Drop the current slot; sampled with the position-8 octet |
| mode | input | 2 | Output format: 00 slot, 01 cell, 10 cell without HEC, 11 payload |
| utopia_sel | input | 1 | Force cell (01) format |
| out_valid | output | 1 | Output octet present |
| out_data | output | 8 | Output octet |
| out_sop | output | 1 | First output octet of a cell |
| out_par | output | 1 | Odd parity over `out_data` |

## Verification
The assertions on cell length assume the following about the input: every slot that reaches its position-8 octet is then delivered complete, and the input never arrives faster than one octet per cycle. Under those conditions each forwarded run between start-of-cell marks is 57, 53, 52 or 48 octets long, and the ring buffer is never written while full. The stimulus respects both conditions. It always sends complete slots, except in the short-slot case of R12, where the slot is cut before position 8 and so never forwards anything. Idle gaps are inserted only between octets, never as a faster burst.

// File: rtl/atm_rx_cell_fmt.sv
module atm_rx_cell_fmt #(
  parameter int SLOT_LEN = 57,
  parameter int OVH_LEN  = 4,
  parameter int HDR_LEN  = 5,
  parameter int DEPTH    = 16,
  parameter logic [31:0] IDLE_HDR = 32'h0000_0001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sos,
  input  logic       in_discard,
  input  logic [1:0] mode,
  input  logic       utopia_sel,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_par
);
  localparam int PW = $clog2(SLOT_LEN);
  localparam int AW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST_P = PW'(SLOT_LEN - 1);
  localparam logic [PW-1:0] OVH_P  = PW'(OVH_LEN);
  localparam logic [PW-1:0] HEC_P  = PW'(OVH_LEN + HDR_LEN - 1);
  localparam logic [PW-1:0] PAY_P  = PW'(OVH_LEN + HDR_LEN);
  localparam logic [PW-1:0] IDL_P  = PW'(OVH_LEN + 3);

  logic [7:0]    mem_d [DEPTH];
  logic [PW-1:0] mem_p [DEPTH];
  logic [AW-1:0] mem_i [DEPTH];

  logic [AW:0]    wr_ptr, rd_ptr;
  logic           in_slot, idle_acc;
  logic [PW-1:0]  wpos, npos;
  logic [AW-1:0]  wid, nid, cid;
  logic [DEPTH-1:0] decided, keep;
  logic [1:0]     smode [DEPTH];

  logic accept, in_win;
  logic [7:0] idle_b;

  assign accept = in_valid && (in_sos || (in_slot && wpos != LAST_P));
  assign npos   = in_sos ? '0 : wpos + 1'b1;
  assign nid    = wid + 1'b1;
  assign cid    = in_sos ? nid : wid;
  assign in_win = npos >= OVH_P && npos <= IDL_P;
  assign idle_b = IDLE_HDR[8*(3 - int'(npos[1:0] - OVH_P[1:0])) +: 8];

  always_ff @(posedge clk) begin
    if (accept) begin
      mem_d[wr_ptr[AW-1:0]] <= in_data;
      mem_p[wr_ptr[AW-1:0]] <= npos;
      mem_i[wr_ptr[AW-1:0]] <= cid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      in_slot  <= 1'b0;
      wpos     <= '0;
      wid      <= '0;
      idle_acc <= 1'b0;
      decided  <= '0;
      keep     <= '0;
      for (int i = 0; i < DEPTH; i++) smode[i] <= 2'b00;
    end else if (accept) begin
      wr_ptr <= wr_ptr + 1'b1;
      wpos   <= npos;
      if (in_sos) begin
        in_slot <= 1'b1;
        wid     <= nid;
        decided[nid] <= 1'b0;
        if (in_slot && !decided[wid]) begin
          decided[wid] <= 1'b1;
          keep[wid]    <= 1'b0;
        end
      end
      if (in_win)
        idle_acc <= (npos == OVH_P ? 1'b1 : idle_acc) && (in_data == idle_b);
      if (npos == HEC_P) begin
        decided[cid] <= 1'b1;
        keep[cid]    <= !idle_acc && !in_discard;
        smode[cid]   <= utopia_sel ? 2'b01 : mode;
      end
    end
  end

  logic [7:0]    r_d;
  logic [PW-1:0] r_p, r_fp;
  logic [AW-1:0] r_i;
  logic [1:0]    r_m;
  logic can_rd, r_sel;

  assign r_d = mem_d[rd_ptr[AW-1:0]];
  assign r_p = mem_p[rd_ptr[AW-1:0]];
  assign r_i = mem_i[rd_ptr[AW-1:0]];
  assign r_m = smode[r_i];
  assign can_rd = (rd_ptr != wr_ptr) && decided[r_i];

  always_comb begin
    case (r_m)
      2'b00:   r_fp = '0;
      2'b11:   r_fp = PAY_P;
      default: r_fp = OVH_P;
    endcase
  end

  assign r_sel = keep[r_i] && r_p >= r_fp && !(r_m == 2'b10 && r_p == HEC_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_par   <= 1'b1;
    end else begin
      out_valid <= can_rd && r_sel;
      if (can_rd) begin
        rd_ptr   <= rd_ptr + 1'b1;
        out_data <= r_d;
        out_sop  <= r_sel && r_p == r_fp;
        out_par  <= ~^r_d;
      end
    end
  end
endmodule

// File: rtl/atm_rx_cell_fmt_chk.sv
module atm_rx_cell_fmt_chk #(
  parameter int AW = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_sop,
  input logic       out_par,
  input logic       accept,
  input logic [AW:0] wr_ptr,
  input logic [AW:0] rd_ptr
);
  logic [6:0] cnt;
  logic       started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      started <= 1'b0;
    end else if (out_valid) begin
      started <= 1'b1;
      cnt <= out_sop ? 7'd1 : cnt + 7'd1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_par_odd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (^{out_par, out_data}) == 1'b1);

  p_cell_sizes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && started) |->
      (cnt == 7'd57 || cnt == 7'd53 || cnt == 7'd52 || cnt == 7'd48));

  p_cell_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> (started && cnt < 7'd57));

  p_ring_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !((wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0])));
endmodule

bind atm_rx_cell_fmt atm_rx_cell_fmt_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_data(out_data),
  .out_sop(out_sop), .out_par(out_par), .accept(accept),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
);

// File: tb/test_atm_rx_cell_fmt.sv
module test_atm_rx_cell_fmt;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sos = 1'b0, in_discard = 1'b0, utopia_sel = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] mode = 2'b00;
  logic out_valid, out_sop, out_par;
  logic [7:0] out_data;

  int checks = 0, failures = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  atm_rx_cell_fmt i_atm_rx_cell_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sos(in_sos), .in_discard(in_discard), .mode(mode), .utopia_sel(utopia_sel),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_par(out_par));

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected octet act=%h exp=none", cur_tag, out_data);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_sop, out_data} != e) begin
          failures++;
          $display("FAIL %s/R10 act sop=%b data=%h exp sop=%b data=%h", t, out_sop, out_data, e[8], e[7:0]);
        end
      end
      checks++;
      if (out_par != ~^out_data) begin
        failures++;
        $display("FAIL R9 parity act=%b exp=%b", out_par, ~^out_data);
      end
    end
  end

  task automatic put(input logic [7:0] d, input logic s, input logic disc);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sos = s; in_discard = disc;
    @(negedge clk);
    in_valid = 1'b0; in_sos = 1'b0; in_discard = 1'b0;
  endtask

  // kind: 0 normal, 1 idle, 2 discard at HEC, 3 discard elsewhere, 4 near-idle
  task automatic send_slot(input int seed, input int kind, input int len,
                           input logic [1:0] m, input logic u, input logic swap,
                           input string tag);
    logic [7:0] b[57];
    int fp, em;
    bit first;
    for (int k = 0; k < 57; k++) b[k] = 8'((k * 37 + seed * 11 + 3) & 255);
    b[4] = 8'hA0 ^ 8'(seed);
    if (kind == 1 || kind == 4) begin
      b[4] = 8'h00; b[5] = 8'h00; b[6] = 8'h00; b[7] = (kind == 1) ? 8'h01 : 8'h02;
    end
    em = u ? 1 : int'(m);
    fp = (em == 0) ? 0 : (em == 3) ? 9 : 4;
    if (len > 8 && kind != 1 && kind != 2) begin
      first = 1;
      for (int k = 0; k < len; k++) begin
        if (k >= fp && !(em == 2 && k == 8)) begin
          exp_q.push_back({first, b[k]});
          tag_q.push_back(tag);
          first = 0;
        end
      end
    end
    mode = m; utopia_sel = u;
    for (int k = 0; k < len; k++) begin
      if (swap && k == 20) begin mode = ~m; utopia_sel = ~u; end
      put(b[k], k == 0, (kind == 2 && k == 8) || (kind == 3 && k == 20));
      if ((seed + k) % 11 == 0) @(negedge clk);
    end
  endtask

  task automatic drain(input string tag);
    repeat (30) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s missing octets act=0 exp=%0d", tag, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin failures++; $display("FAIL R1 act=%b exp=0", out_valid); end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin failures++; $display("FAIL R1 act=%b exp=0", out_valid); end

    cur_tag = "R12";
    for (int k = 0; k < 5; k++) put(8'h33 + 8'(k), 1'b0, 1'b0);
    drain("R12");

    for (int m = 0; m < 4; m++) begin
      for (int u = 0; u < 2; u++) begin
        for (int kind = 0; kind < 5; kind++) begin
          if (u == 1) tg = "R6";
          else if (m == 0) tg = "R2";
          else if (m == 1) tg = "R3";
          else if (m == 2) tg = "R4";
          else tg = "R5";
          if (kind == 1 || kind == 4) tg = "R7";
          if (kind == 2 || kind == 3) tg = "R8";
          cur_tag = tg;
          send_slot(m * 10 + u * 5 + kind, kind, 57, 2'(m), u[0], 1'b0, tg);
        end
        drain(tg);
      end
    end

    cur_tag = "R11";
    for (int m = 0; m < 4; m++) begin
      send_slot(60 + m, 0, 57, 2'(m), 1'b0, 1'b1, "R11");
      send_slot(70 + m, 0, 57, 2'(m), 1'b1, 1'b1, "R11");
    end
    drain("R11");

    cur_tag = "R12";
    send_slot(80, 0, 6, 2'b00, 1'b0, 1'b0, "R12");
    send_slot(81, 0, 57, 2'b10, 1'b0, 1'b0, "R12");
    for (int k = 0; k < 4; k++) put(8'h5A, 1'b0, 1'b0);
    send_slot(82, 0, 3, 2'b11, 1'b0, 1'b0, "R12");
    send_slot(83, 0, 2, 2'b01, 1'b0, 1'b0, "R12");
    send_slot(84, 0, 57, 2'b11, 1'b0, 1'b0, "R12");
    drain("R12");

    cur_tag = "R2";
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      for (int k = 0; k < 57; k++) begin
        in_valid = 1'b1; in_sos = (k == 0); in_discard = 1'b0;
        in_data = 8'((k * 5 + s * 29) & 255);
        if (k == 4) in_data = 8'h11;
        mode = 2'(s % 4); utopia_sel = 1'b0;
        if (k >= 4 + (s % 4 == 3 ? 5 : 0) || s % 4 == 0)
          if (!(s % 4 == 2 && k == 8) && !(s % 4 != 0 && k < 4)) begin
            exp_q.push_back({(k == (s % 4 == 0 ? 0 : s % 4 == 3 ? 9 : 4)), in_data});
            tag_q.push_back("R2");
          end
        @(negedge clk);
      end
      in_valid = 1'b0; in_sos = 1'b0;
    end
    drain("R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule